// File: doc/BRIEF.md
# GPIO Bank Register File with Keyed Pin Locking

This block holds the programmable state of a general-purpose I/O controller. Pins are grouped into banks of 32, and the bank count is set at build time (up to 8). A simple 32-bit memory-mapped bus reads and writes the registers. The bank state is:

- an output latch, with separate write-one-to-set and write-one-to-clear ports;
- an interrupt status word, set by pin events from a neighbouring edge-detect block and cleared by software;
- an interrupt mask, with a separate port that clears mask bits;
- a per-pin lock word.

Every pin also has its own control word, which holds its direction. The block drives the pad output values and output enables. It passes the pending and mask vectors on to the neighbour.

Each lock word guards the configuration of the pins it covers. A lock word can only be rewritten by the first bus access that comes after a key write of a fixed password. Any other access in between disarms the key, so a stray write cannot change which pins are protected.

Top module: `gpio_lockbank_regs`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), the output latch is 0, every interrupt is masked (`irq_mask` all 1), the pending word is 0, and every lock word reads all ones.
- R2: Pin n is bit (n mod 32) of bank n/32. Bank b's registers sit at their group base plus 4·b. Pin n's control word sits at 0x100 + 4·n.
- R3: A write to 0x040 (set) forces to 1 each output-latch bit whose data bit is 1. A write to 0x060 (clear) forces those bits to 0. Data bits that are 0 change nothing. 0x000 reads the latch, and `pad_out` equals the latch.
- R4: A write to the lock word at 0x500 takes effect only if the bus access just before it was a write of 0x00A5A501 to 0x520. In the lock word, 1 locks a pin and 0 unlocks it. The lock word reads back at 0x500.
- R5: Once armed, the key is disarmed by any bus access that is not a repeated correct key write. This includes a read, a key write with a wrong value, and the lock write itself. Idle bus cycles keep the key armed.
- R6: Bit 0 of a control word selects the direction: 1 means input, 0 means output. `pad_oe` is the inverse of that bit. A read of a control word returns the direction bit in bit 0, and all other bits read 0.
- R7: For a locked pin, writes to its control word and to its bits in the set and clear ports are ignored.
- R8: Writing 1 to a bit at 0x0A0 masks that pin, and writing 1 at 0x0C0 unmasks it. Writes to locked pins are ignored. `irq_mask` presents the mask.
- R9: A pulse on `edge_event` sets the pending bit (readable at 0x080). Writing 1 to that bit at 0x080 clears it, whatever the lock state. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: 0x020 reads the pad inputs through a two-flop synchroniser. A change on `pad_in` becomes visible after the second rising clock edge.
- R11: Reads of the set, clear and mask-clear ports, of banks at or beyond NUM_BANKS, and of unmapped offsets return 0. Writes to banks that do not exist change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid during a read access |
| pad_in | input | NUM_BANKS·32 | Pad input levels |
| pad_out | output | NUM_BANKS·32 | Pad drive values |
| pad_oe | output | NUM_BANKS·32 | Pad output enables |
| edge_event | input | NUM_BANKS·32 | One-cycle pin event pulses from the edge detector |
| irq_pending | output | NUM_BANKS·32 | Interrupt status bits |
| irq_mask | output | NUM_BANKS·32 | Interrupt mask bits (1 = masked) |

## Verification
Two functions can meet in the same cycle: the neighbour's event pulse, which sets a pending bit, and the software write-one-to-clear of that same bit. The bench raises `edge_event` on a bit in the very bus cycle that writes 1 to the same bit at 0x080. It then expects the bit to read back set, and only a later clear on its own to remove it. The key sequencing is judged the same way. The bench slips a read or a wrong key between the key and the lock write, and expects the lock word to stay unchanged.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 12;

    localparam logic [WORD_W-1:0] KEY_VALUE = 32'h00A5_A501;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 12'h520;
    localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h100;

    // register group = bus_addr[11:5]
    localparam logic [6:0] GRP_OUT  = 7'h00;
    localparam logic [6:0] GRP_IN   = 7'h01;
    localparam logic [6:0] GRP_SET  = 7'h02;
    localparam logic [6:0] GRP_CLR  = 7'h03;
    localparam logic [6:0] GRP_IST  = 7'h04;
    localparam logic [6:0] GRP_MSK  = 7'h05;
    localparam logic [6:0] GRP_MCLR = 7'h06;
    localparam logic [6:0] GRP_LOCK = 7'h28;

    typedef struct packed {
        logic [WORD_W-1:0] out;
        logic [WORD_W-1:0] dir;   // 1 = input
        logic [WORD_W-1:0] ist;
        logic [WORD_W-1:0] msk;   // 1 = masked
        logic [WORD_W-1:0] lock;  // 1 = locked
    } bank_st_t;

    typedef struct packed {
        logic set;
        logic clr;
        logic ist_clr;
        logic msk;
        logic mclr;
        logic lock;
        logic ctl;
    } bank_wr_t;
endpackage

// File: rtl/gpio_lockbank_sync.sv
module gpio_lockbank_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/gpio_lockbank_key.sv
module gpio_lockbank_key (
    input  logic clk,
    input  logic rst_n,
    input  logic access_i,   // any bus access this cycle
    input  logic key_hit_i,  // correct password written to key address
    output logic armed_o
);
    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t q, d;

    always_comb begin
        d = q;
        if (key_hit_i)     d.armed = 1'b1;
        else if (access_i) d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed_o = q.armed;

    AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && !key_hit_i) |=> !armed_o); // R5
    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit_i |=> armed_o); // R4
endmodule

// File: rtl/gpio_lockbank_bank.sv
module gpio_lockbank_bank
    import gpio_lockbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_wr_t          wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] ctl_sel_i,
    input  logic [WORD_W-1:0] evt_i,
    output bank_st_t          st_o
);
    bank_st_t          q, d;
    logic [WORD_W-1:0] open_w;
    logic [WORD_W-1:0] open_sel;

    always_comb begin
        d        = q;
        open_w   = wdata_i & ~q.lock;
        open_sel = ctl_sel_i & ~q.lock;
        if (wr_i.set)  d.out = q.out | open_w;
        if (wr_i.clr)  d.out = q.out & ~open_w;
        if (wr_i.msk)  d.msk = q.msk | open_w;
        if (wr_i.mclr) d.msk = q.msk & ~open_w;
        if (wr_i.ctl)
            d.dir = (q.dir & ~open_sel) | ({WORD_W{wdata_i[0]}} & open_sel);
        // event wins over a same-cycle clear
        d.ist = (q.ist & ~(wr_i.ist_clr ? wdata_i : '0)) | evt_i;
        if (wr_i.lock) d.lock = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.out  <= '0;
            q.dir  <= '1;
            q.ist  <= '0;
            q.msk  <= '1;
            q.lock <= '1;
        end else begin
            q <= d;
        end
    end

    assign st_o = q;

    AST_LOCKED_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.out ^ $past(q.out)) & $past(q.lock)) == '0); // R7
    AST_LOCKED_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.dir ^ $past(q.dir)) & $past(q.lock)) == '0); // R7
    AST_LOCKED_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.msk ^ $past(q.msk)) & $past(q.lock)) == '0); // R8
    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i) & ~q.ist) == '0); // R9
endmodule

// File: rtl/gpio_lockbank_regs.sv
module gpio_lockbank_regs
    import gpio_lockbank_pkg::*;
#(
    parameter  int unsigned NUM_BANKS = 2,
    localparam int unsigned NPINS     = NUM_BANKS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  edge_event,
    output logic [NPINS-1:0]  irq_pending,
    output logic [NPINS-1:0]  irq_mask
);
    localparam int CTL_END = int'(CTL_BASE) + 4 * int'(NPINS);

    logic [6:0]        grp;
    logic [2:0]        bank_idx;
    logic              ctl_hit;
    logic [ADDR_W-3:0] ctl_pin;
    logic              key_hit;
    logic              armed;
    logic [NPINS-1:0]  sync_in;
    logic [NPINS-1:0]  lock_flat;
    bank_st_t          st [NUM_BANKS];

    assign grp      = bus_addr[11:5];
    assign bank_idx = bus_addr[4:2];
    assign ctl_hit  = (int'(bus_addr) >= int'(CTL_BASE)) && (int'(bus_addr) < CTL_END);
    assign ctl_pin  = (ADDR_W-2)'((bus_addr - CTL_BASE) >> 2);
    assign key_hit  = bus_valid && bus_write && (bus_addr == KEY_ADDR)
                      && (bus_wdata == KEY_VALUE);

    gpio_lockbank_key u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_i  (bus_valid),
        .key_hit_i (key_hit),
        .armed_o   (armed)
    );

    gpio_lockbank_sync #(.WIDTH(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (sync_in)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_wr_t          wr_b;
        logic [WORD_W-1:0] sel_b;

        always_comb begin
            wr_b  = '0;
            sel_b = '0;
            if (bus_valid && bus_write) begin
                if (ctl_hit) begin
                    if (int'(ctl_pin[ADDR_W-3:5]) == b) begin
                        wr_b.ctl              = 1'b1;
                        sel_b[ctl_pin[4:0]]   = 1'b1;
                    end
                end else if (int'(bank_idx) == b) begin
                    case (grp)
                        GRP_SET:  wr_b.set     = 1'b1;
                        GRP_CLR:  wr_b.clr     = 1'b1;
                        GRP_IST:  wr_b.ist_clr = 1'b1;
                        GRP_MSK:  wr_b.msk     = 1'b1;
                        GRP_MCLR: wr_b.mclr    = 1'b1;
                        GRP_LOCK: wr_b.lock    = armed;
                        default:  ;
                    endcase
                end
            end
        end

        gpio_lockbank_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_b),
            .wdata_i   (bus_wdata),
            .ctl_sel_i (sel_b),
            .evt_i     (edge_event[b*WORD_W +: WORD_W]),
            .st_o      (st[b])
        );

        assign pad_out    [b*WORD_W +: WORD_W] = st[b].out;
        assign pad_oe     [b*WORD_W +: WORD_W] = ~st[b].dir;
        assign irq_pending[b*WORD_W +: WORD_W] = st[b].ist;
        assign irq_mask   [b*WORD_W +: WORD_W] = st[b].msk;
        assign lock_flat  [b*WORD_W +: WORD_W] = st[b].lock;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (ctl_hit) begin
                    if (int'(ctl_pin[ADDR_W-3:5]) == b)
                        bus_rdata = {{(WORD_W-1){1'b0}}, st[b].dir[ctl_pin[4:0]]};
                end else if (int'(bank_idx) == b) begin
                    case (grp)
                        GRP_OUT:  bus_rdata = st[b].out;
                        GRP_IN:   bus_rdata = sync_in[b*WORD_W +: WORD_W];
                        GRP_IST:  bus_rdata = st[b].ist;
                        GRP_MSK:  bus_rdata = st[b].msk;
                        GRP_LOCK: bus_rdata = st[b].lock;
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flat != $past(lock_flat)) |-> $past(armed)); // R4
endmodule

// File: tb/gpio_lockbank_regs_test.sv
`timescale 1ns/1ps
module gpio_lockbank_regs_test;
    localparam int NB = 2;
    localparam int NP = 64;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe, edge_event = '0, irq_pending, irq_mask;

    gpio_lockbank_regs #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .edge_event(edge_event), .irq_pending(irq_pending), .irq_mask(irq_mask)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_out [NB], m_dir [NB], m_msk [NB], m_lock [NB], m_ist [NB];

    function automatic logic [63:0] f_out();  return {m_out[1], m_out[0]};   endfunction
    function automatic logic [63:0] f_oe();   return ~{m_dir[1], m_dir[0]};  endfunction
    function automatic logic [63:0] f_msk();  return {m_msk[1], m_msk[0]};   endfunction
    function automatic logic [63:0] f_ist();  return {m_ist[1], m_ist[0]};   endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // tasks are entered at a falling edge and return at a falling edge
    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic op_set(int b, logic [31:0] d);
        wr(12'h040 + 12'(4*b), d); m_out[b] = m_out[b] | (d & ~m_lock[b]);
    endtask
    task automatic op_clr(int b, logic [31:0] d);
        wr(12'h060 + 12'(4*b), d); m_out[b] = m_out[b] & ~(d & ~m_lock[b]);
    endtask
    task automatic op_msk(int b, logic [31:0] d);
        wr(12'h0A0 + 12'(4*b), d); m_msk[b] = m_msk[b] | (d & ~m_lock[b]);
    endtask
    task automatic op_mclr(int b, logic [31:0] d);
        wr(12'h0C0 + 12'(4*b), d); m_msk[b] = m_msk[b] & ~(d & ~m_lock[b]);
    endtask
    task automatic op_ctl(int pin, logic [31:0] d);
        wr(12'h100 + 12'(4*pin), d);
        if (!m_lock[pin/32][pin%32]) m_dir[pin/32][pin%32] = d[0];
    endtask
    task automatic op_lock(int b, logic [31:0] d);
        wr(12'h520, KEY); wr(12'h500 + 12'(4*b), d); m_lock[b] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7331));
        for (int b = 0; b < NB; b++) begin
            m_out[b] = '0; m_dir[b] = '1; m_msk[b] = '1; m_lock[b] = '1; m_ist[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pad_oe, '0);
        check("R1 out", pad_out, '0);
        check("R1 mask", irq_mask, '1);
        check("R1 pending", irq_pending, '0);
        rd(12'h500, v); check("R1 lock0", 64'(v), 64'hFFFF_FFFF);
        rd(12'h504, v); check("R1 lock1", 64'(v), 64'hFFFF_FFFF);

        // R10 two-flop synchroniser
        pad_in = 64'hA5A5_0000_0000_1234;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h020;
        #1 check("R10 before edges", 64'(bus_rdata), 64'h0);
        @(negedge clk); #1 check("R10 after one edge", 64'(bus_rdata), 64'h0);
        @(negedge clk); #1 check("R10 after two edges", 64'(bus_rdata), 64'h1234);
        @(negedge clk); bus_valid = 1'b0;
        rd(12'h024, v); check("R10 R2 bank1 input", 64'(v), 64'hA5A5_0000);

        // R9 events, clear while locked, same-cycle collision
        edge_event = (64'h1 << 5) | (64'h1 << 40);
        @(negedge clk); edge_event = '0;
        m_ist[0][5] = 1'b1; m_ist[1][8] = 1'b1;
        check("R9 R2 pending set", irq_pending, f_ist());
        rd(12'h084, v); check("R9 read bank1", 64'(v), 64'h100);
        edge_event = 64'h1 << 5;
        wr(12'h080, 32'h20);
        edge_event = '0;
        check("R9 event beats clear", irq_pending, f_ist());
        wr(12'h080, 32'h20); m_ist[0][5] = 1'b0;
        check("R9 clear alone", irq_pending, f_ist());
        wr(12'h084, 32'h100); m_ist[1][8] = 1'b0;
        check("R9 clear ignores lock", irq_pending, f_ist());

        // R7 writes to locked pins ignored
        op_set(0, 32'hFFFF_FFFF);
        check("R7 set locked", pad_out, f_out());
        op_ctl(3, 32'h0);
        check("R7 ctl locked", pad_oe, f_oe());

        // R4 lock write without key
        wr(12'h500, 32'h0);
        rd(12'h500, v); check("R4 no key", 64'(v), 64'hFFFF_FFFF);

        // R5 disarming
        wr(12'h520, KEY); rd(12'h000, v); wr(12'h500, 32'h0);
        rd(12'h500, v); check("R5 read disarms", 64'(v), 64'hFFFF_FFFF);
        wr(12'h520, KEY); wr(12'h520, 32'h00A5_A500); wr(12'h500, 32'h0);
        rd(12'h500, v); check("R5 wrong key disarms", 64'(v), 64'hFFFF_FFFF);
        wr(12'h520, KEY); @(negedge clk); @(negedge clk); wr(12'h500, 32'h0);
        m_lock[0] = '0;
        rd(12'h500, v); check("R5 idle keeps armed", 64'(v), 64'h0);
        wr(12'h500, 32'hFFFF_FFFF);
        rd(12'h500, v); check("R5 lock write consumes key", 64'(v), 64'h0);
        wr(12'h520, KEY); wr(12'h520, KEY); wr(12'h500, 32'h0F0F_0F0F);
        m_lock[0] = 32'h0F0F_0F0F;
        rd(12'h500, v); check("R4 key then lock", 64'(v), 64'h0F0F_0F0F);
        op_lock(1, 32'hFFFF_0000);
        rd(12'h504, v); check("R4 bank1 lock", 64'(v), 64'hFFFF_0000);

        // R6 direction and control read-back
        op_ctl(4, 32'h1E0);
        check("R6 pin4 output", pad_oe, f_oe());
        rd(12'h110, v); check("R6 ctl read", 64'(v), 64'h0);
        op_ctl(4, 32'hFFFF_FFFF);
        rd(12'h110, v); check("R6 ctl read input", 64'(v), 64'h1);
        op_ctl(40, 32'h0);
        check("R6 R2 pin40 maps bank1 bit8", pad_oe, 64'h1 << 40);
        op_ctl(50, 32'h0);
        check("R7 pin50 locked", pad_oe, f_oe());

        // R3 set / clear
        op_set(0, 32'hFFFF_FFFF);
        check("R3 set", pad_out, 64'hF0F0_F0F0);
        op_clr(0, 32'h0000_00F0);
        check("R3 clear", pad_out, 64'hF0F0_F000);
        op_set(0, 32'h0);
        check("R3 zero bits", pad_out, f_out());
        rd(12'h000, v); check("R3 readback", 64'(v), 64'hF0F0_F000);

        // R8 mask / unmask
        op_mclr(0, 32'hFFFF_FFFF);
        check("R8 unmask", irq_mask, f_msk());
        op_msk(0, 32'h30);
        check("R8 mask", irq_mask, f_msk());
        rd(12'h0A0, v); check("R8 read", 64'(v), 64'(m_msk[0]));

        // R11 unmapped
        rd(12'h5F0, v); check("R11 unmapped", 64'(v), 64'h0);
        rd(12'h014, v); check("R11 absent bank", 64'(v), 64'h0);
        rd(12'h040, v); check("R11 set port reads 0", 64'(v), 64'h0);
        wr(12'h04C, 32'hFFFF_FFFF);
        check("R11 absent bank write", pad_out, f_out());

        // random mix against model
        for (int i = 0; i < 300; i++) begin
            int b;
            logic [31:0] d;
            b = int'($urandom % NB);
            d = $urandom;
            case ($urandom % 6)
                0: op_set(b, d);
                1: op_clr(b, d);
                2: op_msk(b, d);
                3: op_mclr(b, d);
                4: op_ctl(int'($urandom % NP), d);
                default: op_lock(b, d);
            endcase
            check("R7 random out", pad_out, f_out());
            check("R6 random oe", pad_oe, f_oe());
            check("R8 random mask", irq_mask, f_msk());
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule